// File: doc/BRIEF.md
# Seven-Source Two-Level Interrupt Arbiter

This block decides which interrupt an 8051-class core takes next. Seven sources compete: four active-low external lines, the two timer overflow flags and the serial port flag. The core supplies the enable and priority bits for the five classic sources and the trigger type for the first two external lines. The two extra external lines are set up through one bit-addressable extension register. Each of them has a priority bit, an enable bit, a request flag and a trigger-type bit in that register. The register is loaded through a write strobe with an 8-bit data word.

Each external line passes through a two-flop synchroniser. The line then sets a request flag, either on a falling edge (edge mode) or for as long as it stays low (level mode). Of the enabled requests the block picks one, first by priority level and then by a fixed polling order. It presents a request, the entry vector of the winner and the winner's level. When the core acknowledges, the block records the level as in service and clears the winner's flag if that flag is edge-triggered. While a level is in service, requests at that level or a lower one are held back. A return strobe releases the most recent level.

Top module: `irq_arbiter7`

## Requirements
- R1: The extension register is written whole by `xcon_we_i`. Its bits are: bit 0 trigger type of external 2 (1 = falling edge, 0 = low level), bit 1 request flag of external 2, bit 2 enable of external 2, bit 3 priority of external 2 (1 = high), and bits 4 to 7 the same four fields for external 3.
- R2: Source indices 0 to 6 are external 0, timer 0, external 1, timer 1, serial, external 2 and external 3. Their vectors are 03h, 0Bh, 13h, 1Bh, 23h, 33h and 3Bh.
- R3: Among eligible requests at the same level, the lowest source index wins.
- R4: An eligible high-priority request wins over every low-priority request, whatever their indices. `lvl_o` is 1 when the winner is high priority.
- R5: In edge mode, a falling edge on an external line sets its flag after three clock edges (two synchroniser stages plus the flag register). The flag stays set after the line goes high again.
- R6: Acknowledging an edge-triggered external source clears its flag, so it does not request again without a new edge.
- R7: In level mode, an external flag equals the inverted synchronised line, three edges after the pin. An acknowledge does not clear it.
- R8: A source whose enable is 0 never raises `irq_o`, but its flag is kept. Enabling the source later raises the request.
- R9: An acknowledge (`ack_i` while `irq_o` is 1) marks the winner's level as in service. While high is in service, nothing is requested. While only low is in service, only high-priority requests are.
- R10: A `reti_i` pulse clears the high in-service mark if it is set, and otherwise the low one.
- R11: After reset, there is no request, all flags are clear, the extension register is zero and no level is in service.
- R12: The timer and serial requests follow `periph_req_i` and are not cleared by an acknowledge.
- R13: In edge mode, a register write sets or clears the flag of external 2 or 3 directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n_i | input | 4 | Raw external interrupt lines 0..3, active low |
| trig_edge_i | input | 2 | Trigger type of external 0 and 1 (1 = falling edge) |
| periph_req_i | input | 3 | Request flags: timer 0, timer 1, serial |
| en_i | input | 5 | Enables: ext0, timer0, ext1, timer1, serial |
| pri_i | input | 5 | Priorities in the same order (1 = high) |
| xcon_we_i | input | 1 | Extension register write strobe |
| xcon_wdata_i | input | 8 | Extension register write data |
| ack_i | input | 1 | Core takes the presented interrupt |
| reti_i | input | 1 | Return from interrupt |
| irq_o | output | 1 | Request to the core |
| vec_o | output | 8 | Vector of the winner |
| lvl_o | output | 1 | Priority level of the winner |

## Verification
Every cycle, the assertions check the following. The vector always comes from the seven legal values. An acknowledge at high level silences all requests in the next cycle. An acknowledge at low level leaves only high-level requests. An edge flag holds while nothing acknowledges or rewrites it. Other behaviour is shown only by the bench scenarios, which compare against a behavioural model: polling order against priority, synchroniser latency, level versus edge flag lifetime, release order on return, and software setting of flags.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 7;
  localparam int NEXT = 4;
  localparam int IDXW = $clog2(NSRC);
  typedef logic [IDXW-1:0] src_idx_t;

  // vector = 03h + 8*slot; slot 5 is skipped between serial and external 2
  function automatic logic [7:0] vec_of(src_idx_t idx);
    logic [7:0] slot;
    slot = 8'(idx);
    if (idx >= src_idx_t'(5)) slot = slot + 8'd1;
    return 8'h03 + (slot << 3);
  endfunction

  // source index of external line k
  function automatic src_idx_t ext_src(int k);
    case (k)
      0:       return src_idx_t'(0);
      1:       return src_idx_t'(2);
      2:       return src_idx_t'(5);
      default: return src_idx_t'(6);
    endcase
  endfunction
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic active,
  output logic fall
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], line_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign active = ~sh_q[STAGES-1];
  assign fall   = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] req_hi,
  input  logic [N-1:0] req_lo,
  output logic         valid,
  output src_idx_t     idx,
  output logic         lvl
);
  src_idx_t idx_hi, idx_lo;

  always_comb begin
    idx_hi = '0;
    idx_lo = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_hi[i]) idx_hi = src_idx_t'(i);
      if (req_lo[i]) idx_lo = src_idx_t'(i);
    end
    valid = |req_hi | |req_lo;
    lvl   = |req_hi;
    idx   = lvl ? idx_hi : idx_lo;
  end
endmodule

// File: rtl/irq_arbiter7.sv
module irq_arbiter7
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ext_n_i,
  input  logic [1:0] trig_edge_i,
  input  logic [2:0] periph_req_i,
  input  logic [4:0] en_i,
  input  logic [4:0] pri_i,
  input  logic       xcon_we_i,
  input  logic [7:0] xcon_wdata_i,
  input  logic       ack_i,
  input  logic       reti_i,
  output logic       irq_o,
  output logic [7:0] vec_o,
  output logic       lvl_o
);
  logic [NEXT-1:0] act, fall;
  logic [NEXT-1:0] flag_q, flag_d;
  logic [1:0]      xc_it_q, xc_en_q, xc_pri_q;
  logic [1:0]      xc_it_d, xc_en_d, xc_pri_d;
  logic            ins_hi_q, ins_lo_q, ins_hi_d, ins_lo_d;
  logic [NSRC-1:0] req, pri, req_hi, req_lo;
  logic [NEXT-1:0] edge_mode, sw_we, sw_val;
  logic            win_valid, win_lvl, take;
  src_idx_t        win_idx;

  for (genvar k = 0; k < NEXT; k++) begin : g_sync
    irq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_n (ext_n_i[k]),
      .active (act[k]),
      .fall   (fall[k])
    );
  end

  assign req = {flag_q[3] & xc_en_q[1], flag_q[2] & xc_en_q[0],
                periph_req_i[2] & en_i[4], periph_req_i[1] & en_i[3],
                flag_q[1] & en_i[2], periph_req_i[0] & en_i[1],
                flag_q[0] & en_i[0]};
  assign pri    = {xc_pri_q, pri_i};
  assign req_hi = req & pri & {NSRC{~ins_hi_q}};
  assign req_lo = req & ~pri & {NSRC{~ins_hi_q & ~ins_lo_q}};

  irq_pick #(.N(NSRC)) u_pick (
    .req_hi (req_hi),
    .req_lo (req_lo),
    .valid  (win_valid),
    .idx    (win_idx),
    .lvl    (win_lvl)
  );

  assign irq_o = win_valid;
  assign vec_o = vec_of(win_idx);
  assign lvl_o = win_lvl;
  assign take  = ack_i & win_valid;

  assign edge_mode = {xc_it_q, trig_edge_i};
  assign sw_we     = {{2{xcon_we_i}}, 2'b00};
  assign sw_val    = {xcon_wdata_i[5], xcon_wdata_i[1], 2'b00};

  always_comb begin
    for (int k = 0; k < NEXT; k++) begin
      flag_d[k] = flag_q[k];
      if (edge_mode[k]) begin
        if (take && win_idx == ext_src(k)) flag_d[k] = 1'b0;
        if (sw_we[k])                      flag_d[k] = sw_val[k];
        if (fall[k])                       flag_d[k] = 1'b1;
      end else begin
        flag_d[k] = act[k];
      end
    end
  end

  always_comb begin
    ins_hi_d = ins_hi_q;
    ins_lo_d = ins_lo_q;
    if (reti_i) begin
      if (ins_hi_q) ins_hi_d = 1'b0;
      else          ins_lo_d = 1'b0;
    end
    if (take) begin
      if (win_lvl) ins_hi_d = 1'b1;
      else         ins_lo_d = 1'b1;
    end
  end

  always_comb begin
    xc_it_d  = {xcon_wdata_i[4], xcon_wdata_i[0]};
    xc_en_d  = {xcon_wdata_i[6], xcon_wdata_i[2]};
    xc_pri_d = {xcon_wdata_i[7], xcon_wdata_i[3]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      ins_hi_q <= 1'b0;
      ins_lo_q <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      ins_hi_q <= ins_hi_d;
      ins_lo_q <= ins_lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xc_it_q  <= '0;
      xc_en_q  <= '0;
      xc_pri_q <= '0;
    end else if (xcon_we_i) begin
      xc_it_q  <= xc_it_d;
      xc_en_q  <= xc_en_d;
      xc_pri_q <= xc_pri_d;
    end
  end
endmodule

// File: rtl/irq_arbiter7_chk.sv
module irq_arbiter7_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_i,
  input logic       xcon_we_i,
  input logic       irq_o,
  input logic [7:0] vec_o,
  input logic       lvl_o,
  input logic       it2,
  input logic       flag2
);
  // R2
  legal_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o inside {8'h03, 8'h0B, 8'h13, 8'h1B, 8'h23, 8'h33, 8'h3B}));

  // R9
  high_service_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && lvl_o) |=> !irq_o);

  // R9
  low_service_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !lvl_o) |=> (!irq_o || lvl_o));

  // R5
  edge_flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (it2 && flag2 && !ack_i && !xcon_we_i) |=> flag2);
endmodule

bind irq_arbiter7 irq_arbiter7_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack_i     (ack_i),
  .xcon_we_i (xcon_we_i),
  .irq_o     (irq_o),
  .vec_o     (vec_o),
  .lvl_o     (lvl_o),
  .it2       (xc_it_q[0]),
  .flag2     (flag_q[2])
);

// File: tb/test_irq_arbiter7.sv
module test_irq_arbiter7;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_n_i = 4'hF;
  logic [1:0] trig_edge_i = 2'b00;
  logic [2:0] periph_req_i = 3'b000;
  logic [4:0] en_i = 5'b0, pri_i = 5'b0;
  logic       xcon_we_i = 1'b0;
  logic [7:0] xcon_wdata_i = 8'h00;
  logic       ack_i = 1'b0, reti_i = 1'b0;
  logic       irq_o, lvl_o;
  logic [7:0] vec_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_arbiter7 i_irq_arbiter7 (
    .clk(clk), .rst_n(rst_n), .ext_n_i(ext_n_i), .trig_edge_i(trig_edge_i),
    .periph_req_i(periph_req_i), .en_i(en_i), .pri_i(pri_i),
    .xcon_we_i(xcon_we_i), .xcon_wdata_i(xcon_wdata_i),
    .ack_i(ack_i), .reti_i(reti_i),
    .irq_o(irq_o), .vec_o(vec_o), .lvl_o(lvl_o));

  // ---------------- behavioural reference model ----------------
  int m_p1[4], m_p2[4], m_p3[4];
  bit m_flag[4];
  bit m_it[2], m_ex[2], m_px[2];
  bit m_hi, m_lo;
  int vectors[7] = '{3, 11, 19, 27, 35, 51, 59};
  int ext_slot[4] = '{0, 2, 5, 6};

  function automatic void m_reqs(output bit rq[7], output bit pr[7]);
    rq[0] = m_flag[0] && en_i[0];          pr[0] = pri_i[0];
    rq[1] = periph_req_i[0] && en_i[1];    pr[1] = pri_i[1];
    rq[2] = m_flag[1] && en_i[2];          pr[2] = pri_i[2];
    rq[3] = periph_req_i[1] && en_i[3];    pr[3] = pri_i[3];
    rq[4] = periph_req_i[2] && en_i[4];    pr[4] = pri_i[4];
    rq[5] = m_flag[2] && m_ex[0];          pr[5] = m_px[0];
    rq[6] = m_flag[3] && m_ex[1];          pr[6] = m_px[1];
  endfunction

  // returns winner index or -1; lv = winner level
  function automatic int m_winner(output bit lv);
    bit rq[7], pr[7];
    m_reqs(rq, pr);
    lv = 0;
    if (!m_hi)
      for (int i = 0; i < 7; i++) if (rq[i] && pr[i]) begin lv = 1; return i; end
    if (!m_hi && !m_lo)
      for (int i = 0; i < 7; i++) if (rq[i] && !pr[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        m_p1[k] = 1; m_p2[k] = 1; m_p3[k] = 1; m_flag[k] = 0;
      end
      for (int j = 0; j < 2; j++) begin m_it[j] = 0; m_ex[j] = 0; m_px[j] = 0; end
      m_hi = 0; m_lo = 0;
    end else begin
      bit lv;
      int w;
      bit em;
      w = m_winner(lv);
      for (int k = 0; k < 4; k++) begin
        em = (k < 2) ? trig_edge_i[k] : m_it[k-2];
        if (em) begin
          if (ack_i && w == ext_slot[k]) m_flag[k] = 0;
          if (k >= 2 && xcon_we_i) m_flag[k] = xcon_wdata_i[4*(k-2)+1];
          if (m_p3[k] == 1 && m_p2[k] == 0) m_flag[k] = 1;
        end else begin
          m_flag[k] = (m_p2[k] == 0);
        end
      end
      if (reti_i) begin
        if (m_hi) m_hi = 0; else m_lo = 0;
      end
      if (ack_i && w >= 0) begin
        if (lv) m_hi = 1; else m_lo = 1;
      end
      if (xcon_we_i)
        for (int j = 0; j < 2; j++) begin
          m_it[j] = xcon_wdata_i[4*j];
          m_ex[j] = xcon_wdata_i[4*j+2];
          m_px[j] = xcon_wdata_i[4*j+3];
        end
      for (int k = 0; k < 4; k++) begin
        m_p3[k] = m_p2[k]; m_p2[k] = m_p1[k]; m_p1[k] = ext_n_i[k];
      end
    end
  end

  // per-cycle comparison against the model (R2 R3 R4 R9 in every cycle)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit lv;
      int w;
      w = m_winner(lv);
      checks++;
      if (irq_o !== (w >= 0) ||
          (w >= 0 && (vec_o !== 8'(vectors[w]) || lvl_o !== lv))) begin
        fails++;
        $display("FAIL model compare R3 R4: got irq=%0d vec=%02h lvl=%0d exp irq=%0d vec=%02h lvl=%0d",
                 irq_o, vec_o, lvl_o, (w >= 0), (w >= 0) ? vectors[w] : 0, lv);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(string tag, int got, int exp);
    @(negedge clk);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr_x(logic [7:0] d);
    xcon_we_i = 1'b1; xcon_wdata_i = d; tick(1); xcon_we_i = 1'b0;
  endtask

  task automatic do_ack;  ack_i = 1'b1;  tick(1); ack_i = 1'b0;  endtask
  task automatic do_reti; reti_i = 1'b1; tick(1); reti_i = 1'b0; endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: got hung run expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    chk("R11 reset no request", irq_o, 0);

    // R1 R5: edge mode on external 2
    wr_x(8'h05);
    ext_n_i[2] = 1'b0;
    tick(2);
    chk("R5 latency not yet", irq_o, 0);
    tick(1);
    chk("R5 edge flag raises irq", irq_o, 1);
    chk("R2 ext2 vector", vec_o, 8'h33);
    chk("R1 ext2 low priority", lvl_o, 0);
    ext_n_i[2] = 1'b1;
    tick(4);
    chk("R5 flag held after line high", irq_o, 1);
    do_ack();
    chk("R9 low in service", irq_o, 0);
    do_reti();
    chk("R6 edge flag cleared by ack", irq_o, 0);

    // R3 R4 R9 R10 R12: timer 0 and serial
    en_i = 5'b10010; periph_req_i = 3'b101;
    tick(1);
    chk("R3 timer0 before serial", vec_o, 8'h0B);
    do_ack();
    chk("R9 low level blocks low", irq_o, 0);
    pri_i = 5'b10000;
    tick(1);
    chk("R4 high serial nests", vec_o, 8'h23);
    chk("R4 level output", lvl_o, 1);
    do_ack();
    chk("R9 high level blocks all", irq_o, 0);
    do_reti();
    chk("R10 high released first", vec_o, 8'h23);
    chk("R12 serial not cleared by ack", irq_o, 1);
    do_reti();
    chk("R4 high wins over lower index", vec_o, 8'h23);
    periph_req_i = 3'b000; pri_i = 5'b0; en_i = 5'b0;

    // R7: level mode on external 0
    trig_edge_i = 2'b00; en_i = 5'b00001; ext_n_i[0] = 1'b0;
    tick(3);
    chk("R7 level request", vec_o, 8'h03);
    do_ack();
    chk("R9 blocked in service", irq_o, 0);
    do_reti();
    chk("R7 level not cleared by ack", irq_o, 1);
    ext_n_i[0] = 1'b1;
    tick(3);
    chk("R7 follows line release", irq_o, 0);
    en_i = 5'b0;

    // R8: disabled source keeps flag
    wr_x(8'h01);
    ext_n_i[2] = 1'b0; tick(2); ext_n_i[2] = 1'b1; tick(4);
    chk("R8 disabled no irq", irq_o, 0);
    wr_x(8'h07);
    chk("R8 flag kept, now enabled", vec_o, 8'h33);
    do_ack(); do_reti();
    chk("R6 cleared after ack", irq_o, 0);

    // R13 R1 R4: software flag on external 3
    en_i = 5'b00010; periph_req_i = 3'b001;
    wr_x(8'h70);
    chk("R3 timer0 beats ext3 at low", vec_o, 8'h0B);
    wr_x(8'hF0);
    chk("R1 R4 ext3 high via bit7", vec_o, 8'h3B);
    wr_x(8'hD0);
    chk("R13 software clear of flag", vec_o, 8'h0B);
    en_i = 5'b0; periph_req_i = 3'b000;
    tick(2);
    finish_run();
  end
endmodule